// File: doc/BRIEF.md
# Halfword Exchange Saturating Add/Subtract Unit

This unit is a single-stage datapath that splits each of two 32-bit operands into a signed upper and a signed lower 16-bit halfword. It pairs each halfword of the first operand with the *opposite* halfword of the second operand. It then does one addition and one subtraction across those crossed pairs. Each lane result is clamped on its own to the signed 16-bit range, so one lane can saturate while the other does not.

A one-bit mode input picks which lane adds and which lane subtracts. The result is held in an output register behind a valid/ready handshake on both sides. A transfer happens on a rising clock edge when valid and ready are both high. The output register holds its data while the consumer stalls. The input side is ready whenever that register is empty or is being drained in the same cycle, so with `out_ready` held high the unit accepts one operation per clock. The unit keeps no sticky saturation status.

Top module: `hx_addsub_xchg`

## Requirements
- R1: With `in_mode`=1, result bits [31:16] equal sat16(a[31:16] − b[15:0]).
- R2: With `in_mode`=1, result bits [15:0] equal sat16(a[15:0] + b[31:16]).
- R3: With `in_mode`=0, result bits [31:16] equal sat16(a[31:16] + b[15:0]).
- R4: With `in_mode`=0, result bits [15:0] equal sat16(a[15:0] − b[31:16]).
- R5: sat16 clamps a result above 32767 to 0x7FFF and a result below −32768 to 0x8000, and never wraps. In-range values, including exactly 0x7FFF and 0x8000, pass through unchanged. Each lane clamps independently of the other.
- R6: An input accepted at a rising edge (`in_valid` and `in_ready` both high) appears on `out_data`, with `out_valid` high, right after that same edge.
- R7: A synchronous active-high `rst` clears `out_valid` at the next rising edge. After reset, `in_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values and `in_ready` is low. An input offered during the stall is not taken.
- R9: `in_ready` is high when `out_valid` is low or `out_ready` is high. With `out_ready` held high, back-to-back inputs give back-to-back results.
- R10: A cycle with `in_valid` low leaves no result. If the register was drained or was empty, `out_valid` is low after that edge, whatever the operand and mode inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_mode | input | 1 | 0: add upper / subtract lower; 1: subtract upper / add lower |
| in_a | input | 32 | First operand, two signed halfwords |
| in_b | input | 32 | Second operand, two signed halfwords (crossed) |
| out_valid | output | 1 | `out_data` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Two saturated signed halfword results |

## Verification
Every result is due exactly one rising edge after the edge that accepts its operands. The arithmetic is combinational ahead of the single output register. The bench drives inputs on the falling edge and checks `out_data` and `out_valid` on the next falling edge, which is half a period after the register loads. For stalls it keeps sampling on later falling edges to show the held value has not moved. It then sees the queued operation appear one edge after `out_ready` rises.

// File: rtl/hx_pkg.sv
package hx_pkg;
  typedef enum logic {
    MODE_ADD_HI = 1'b0,
    MODE_SUB_HI = 1'b1
  } hx_mode_e;
endpackage

// File: rtl/hx_lane.sv
module hx_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] z
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] xe, ye, wide;
  logic       out_of_range;

  always_comb begin
    xe = {x[W-1], x};
    ye = {y[W-1], y};
    wide = sub ? (xe - ye) : (xe + ye);
    out_of_range = wide[W] ^ wide[W-1];
    if (out_of_range) z = wide[W] ? NEG_MIN : POS_MAX;
    else              z = wide[W-1:0];
  end
endmodule

// File: rtl/hx_xchg_core.sv
module hx_xchg_core
  import hx_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int DW = 2 * LANE_W
) (
  input  hx_mode_e        mode,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic sub_g;
    assign sub_g = (g == 1) ? (mode == MODE_SUB_HI) : (mode == MODE_ADD_HI);
    hx_lane #(.W(LANE_W)) u_lane (
      .x  (a[g*LANE_W +: LANE_W]),
      .y  (b[(1-g)*LANE_W +: LANE_W]),
      .sub(sub_g),
      .z  (res[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/hx_out_reg.sv
module hx_out_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (rst)                     dn_valid <= 1'b0;
    else if (take)               dn_valid <= 1'b1;
    else if (dn_ready)           dn_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) dn_data <= up_data;
  end

  assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready) |=> (dn_valid && dn_data == $past(up_data)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  assert_drain_R10: assert property (@(posedge clk) disable iff (rst)
    (!up_valid && (dn_ready || !dn_valid)) |=> !dn_valid);
endmodule

// File: rtl/hx_addsub_xchg.sv
module hx_addsub_xchg
  import hx_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int DW = 2 * LANE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_mode,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] core_res;

  hx_xchg_core #(.LANE_W(LANE_W)) u_core (
    .mode(hx_mode_e'(in_mode)),
    .a   (in_a),
    .b   (in_b),
    .res (core_res)
  );

  hx_out_reg #(.DW(DW)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (core_res),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (out_data)
  );

  // Sum of two non-negative halfwords must never come out negative (no wrap)
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_mode && !in_a[DW-1] && !in_b[LANE_W-1])
      |=> !out_data[DW-1]);

  // Negative minus non-negative must stay negative (clamps at most to the minimum)
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_mode && in_a[LANE_W-1] && !in_b[DW-1])
      |=> out_data[LANE_W-1]);

  // Non-negative minus negative in the upper lane of mode 1 stays non-negative
  assert_no_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mode && !in_a[DW-1] && in_b[LANE_W-1])
      |=> !out_data[DW-1]);

  // Two negative halfwords added in the lower lane of mode 1 stay negative
  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mode && in_a[LANE_W-1] && in_b[DW-1])
      |=> out_data[LANE_W-1]);
endmodule

// File: tb/sim_hx_addsub_xchg.sv
module sim_hx_addsub_xchg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mode = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  hx_addsub_xchg u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [15:0] sat16(input int v);
    if (v > 32767)       return 16'h7FFF;
    else if (v < -32768) return 16'h8000;
    else                 return v[15:0];
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic m);
    int ah, al, bh, bl;
    ah = int'($signed(a[31:16])); al = int'($signed(a[15:0]));
    bh = int'($signed(b[31:16])); bl = int'($signed(b[15:0]));
    if (m) return {sat16(ah - bl), sat16(al + bh)};
    else   return {sat16(ah + bl), sat16(al - bh)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one op with out_ready high; result checked one edge later
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b, input logic m);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_mode = m;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk(req, out_data, model(a, b, m));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R7 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R7 in_ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_mode_sub_hi;
    run_op("R1 R2 mode1", 32'h0010_0020, 32'h0003_0005, 1'b1);
    run_op("R1 R2 mode1 signs", 32'hFFF0_0005, 32'hFFFE_0010, 1'b1);
  endtask

  task automatic t_mode_add_hi;
    run_op("R3 R4 mode0", 32'h0010_0020, 32'h0003_0005, 1'b0);
    run_op("R3 R4 mode0 signs", 32'h1234_8001, 32'hFFFF_EDCC, 1'b0);
  endtask

  task automatic t_saturate;
    run_op("R5 R3 pos clamp / R4 neg clamp", 32'h7000_8000, 32'h0001_2000, 1'b0);
    chk("R5 expected constant", model(32'h7000_8000, 32'h0001_2000, 1'b0), 32'h7FFF_8000);
    run_op("R5 R1 neg clamp / R2 pos clamp", 32'h8000_7FFF, 32'h0001_0001, 1'b1);
    chk("R5 expected constant mode1", model(32'h8000_7FFF, 32'h0001_0001, 1'b1), 32'h8000_7FFF);
    run_op("R5 exact limits no clamp", 32'h7FFE_8001, 32'h0001_0001, 1'b0);
    run_op("R5 one lane only", 32'h7FFF_0005, 32'h0003_0001, 1'b0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_valid = 1'b1; in_a = 32'h0100_0200; in_b = 32'h0030_0040; in_mode = 1'b0;
    @(negedge clk);
    chk("R9 stream first", out_data, model(32'h0100_0200, 32'h0030_0040, 1'b0));
    chk("R9 ready while draining", {31'd0, in_ready}, 32'd1);
    in_a = 32'hF000_0FFF; in_b = 32'h1111_2222; in_mode = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 R9 stream second", out_data, model(32'hF000_0FFF, 32'h1111_2222, 1'b1));
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = 32'h0001_0002; in_b = 32'h0003_0004; in_mode = 1'b0;
    @(negedge clk);
    chk("R6 loaded under stall", out_data, model(32'h0001_0002, 32'h0003_0004, 1'b0));
    in_a = 32'h0100_0100; in_b = 32'h0200_0300; in_mode = 1'b1;
    chk("R8 not ready", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R8 data held", out_data, model(32'h0001_0002, 32'h0003_0004, 1'b0));
    chk("R8 valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 R9 queued op after release", out_data, model(32'h0100_0100, 32'h0200_0300, 1'b1));
    @(negedge clk);
    chk("R10 empty after drain", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    in_valid = 1'b0; in_a = 32'hDEAD_BEEF; in_b = 32'h1234_5678; in_mode = 1'b1;
    @(negedge clk);
    chk("R10 no result without valid", {31'd0, out_valid}, 32'd0);
    chk("R10 last result unchanged", out_data, model(32'h0100_0100, 32'h0200_0300, 1'b1));
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = 32'h0005_0005; in_b = 32'h0005_0005; in_mode = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R7 reset clears held result", {31'd0, out_valid}, 32'd0);
    chk("R7 ready after reset", {31'd0, in_ready}, 32'd1);
    out_ready = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode_sub_hi();
    t_mode_add_hi();
    t_saturate();
    t_stream();
    t_backpressure();
    t_ignore();
    t_reset_mid();
    run_op("R6 after reset", 32'h0002_0003, 32'h0004_0005, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule